// File: doc/BRIEF.md
# Dual-Bank Interrupt Routing Controller

This block gathers forty level-sensitive interrupt inputs and delivers them to a processor core on two request lines: a normal interrupt and a fast interrupt. Sources 0 to 31 form the low bank and sources 32 to 39 form the high bank. Each bank has an enable register and a route register. Every source has one enable bit and one route bit that selects which of the two lines it drives. A third output asks a halted core to wake. A single control bit decides whether a disabled but active source may also trigger that wake request.

Software sees the block through a 32-bit register port with byte offsets. It can write the enables, the routes and the wake control. It can read these back, together with three views of the pending state: the raw input levels, the enabled sources routed to the normal line, and the enabled sources routed to the fast line. Arbitration between sources by priority is done elsewhere. Every output and every read result comes straight from flops, so each one responds exactly one clock edge after its cause.

Top module: `dual_bank_irq_router`

## Requirements
- R1: The pending bit of each source is the level of its input captured at the previous clock edge, with no latching. The raw pending views at 0x10 (low bank) and 0xAC (high bank) return these bits.
- R2: Source n is bit n mod 32 of bank n/32. The high bank holds only bits 7..0, and bits 31..8 of every high-bank register read as zero.
- R3: The enable registers (0x04 low, 0xA0 high) and the route registers (0x08 low, 0xA4 high) take a written value at the clock edge of the write and read back what they hold. All four reset to zero.
- R4: fiq_out is 1 exactly when some source has its pending, enable and route bits all set, counting both banks.
- R5: irq_out is 1 exactly when some source has its pending and enable bits set and its route bit clear.
- R6: The normal-line view (0x00 low, 0x9C high) reads pending & enable & ~route. The fast-line view (0x0C low, 0xA8 high) reads pending & enable & route.
- R7: Bit 0 of the control register at offset 0x14 selects strict wake when it is 1. In strict wake, only enabled sources raise wake_out. The register reads back as {31'b0, bit0} and resets to 1.
- R8: wake_out is 1 exactly when cpu_halted was 1 at the previous edge and some pending source is enabled, or strict wake is off.
- R9: Writes to the pending views or to any unmapped offset change no state. A read of an unmapped offset returns zero.
- R10: reg_rdata shows the register at the reg_addr sampled at the previous edge, as it was before that edge. A write or an input change shows on irq_out, fiq_out and wake_out one edge after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| src_level | input | 40 | Interrupt input levels, one per source |
| cpu_halted | input | 1 | High while the core is halted |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Byte offset of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| irq_out | output | 1 | Normal interrupt request to the core |
| fiq_out | output | 1 | Fast interrupt request to the core |
| wake_out | output | 1 | Wake request to a halted core |

## Verification
The hardest case to reach is a wake request from a source that is pending but disabled. It needs strict wake switched off, a halted core and an active disabled input all at once, and at that moment neither interrupt line may move. Random stimulus writes only a few enable bits and toggles the control bit, so this mix comes up often. A directed sequence also sets it up by hand and then turns strict wake back on to show the request drop. Writes aimed at the pending views and at unmapped offsets are mixed into the random traffic. The model then shows at once if any of these writes disturbed the state.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 8;

    // Offset of the wake-control register
    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h14;

    // Offsets inside one bank window, relative to its base
    localparam logic [ADDR_W-1:0] REL_IRQ   = 8'h00;
    localparam logic [ADDR_W-1:0] REL_MASK  = 8'h04;
    localparam logic [ADDR_W-1:0] REL_ROUTE = 8'h08;
    localparam logic [ADDR_W-1:0] REL_FIQ   = 8'h0C;
    localparam logic [ADDR_W-1:0] REL_RAW   = 8'h10;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_IRQ,
        SEL_MASK,
        SEL_ROUTE,
        SEL_FIQ,
        SEL_RAW
    } bank_sel_e;

    typedef struct packed {
        logic irq_req;
        logic fiq_req;
        logic wake_req;
    } bank_flags_t;

    // Window base of bank b: first bank at zero, later banks after the priority area
    function automatic logic [ADDR_W-1:0] bank_base(input int b);
        if (b == 0) return 8'h00;
        return 8'h9C + ADDR_W'(20 * (b - 1));
    endfunction

    function automatic bank_sel_e decode_bank(input logic [ADDR_W-1:0] addr,
                                              input logic [ADDR_W-1:0] base);
        logic [ADDR_W-1:0] rel;
        rel = addr - base;
        case (rel)
            REL_IRQ:   return SEL_IRQ;
            REL_MASK:  return SEL_MASK;
            REL_ROUTE: return SEL_ROUTE;
            REL_FIQ:   return SEL_FIQ;
            REL_RAW:   return SEL_RAW;
            default:   return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/irq_bank.sv
module irq_bank
    import irq_router_pkg::*;
#(
    parameter int W = 32,
    parameter logic [ADDR_W-1:0] BASE = 8'h00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [W-1:0]      src,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    input  logic              wake_strict,
    output bank_flags_t       flags,
    output logic [WORD_W-1:0] rd_val,
    output logic              rd_hit
);

    logic [W-1:0] pend_q;
    logic [W-1:0] en_q;
    logic [W-1:0] route_q;
    logic [W-1:0] live;
    logic [W-1:0] view;
    bank_sel_e    sel;

    assign sel = decode_bank(addr, BASE);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= '0;
            en_q    <= '0;
            route_q <= '0;
        end else begin
            pend_q <= src;
            if (wr_en && sel == SEL_MASK)  en_q    <= wdata;
            if (wr_en && sel == SEL_ROUTE) route_q <= wdata;
        end
    end

    assign live = pend_q & en_q;

    always_comb begin
        flags.irq_req  = |(live & ~route_q);
        flags.fiq_req  = |(live & route_q);
        flags.wake_req = |(pend_q & (en_q | {W{~wake_strict}}));
    end

    always_comb begin
        case (sel)
            SEL_IRQ:   view = live & ~route_q;
            SEL_FIQ:   view = live & route_q;
            SEL_MASK:  view = en_q;
            SEL_ROUTE: view = route_q;
            SEL_RAW:   view = pend_q;
            default:   view = '0;
        endcase
        rd_val         = '0;
        rd_val[W-1:0]  = view;
        rd_hit         = (sel != SEL_NONE);
    end

    AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && sel == SEL_MASK) |=> $stable(en_q)); // R9
    AST_ROUTE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && sel == SEL_ROUTE) |=> $stable(route_q)); // R9

endmodule

// File: rtl/irq_idle_ctrl.sv
module irq_idle_ctrl
    import irq_router_pkg::*;
#(
    parameter int NB = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wbit,
    input  logic              cpu_halted,
    input  logic [NB-1:0]     bank_wake,
    output logic              wake_strict,
    output logic              wake_out,
    output logic [WORD_W-1:0] ctrl_rd,
    output logic              ctrl_hit
);

    logic strict_q;
    logic halted_q;

    assign ctrl_hit = (addr == OFS_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            strict_q <= 1'b1;
            halted_q <= 1'b0;
        end else begin
            halted_q <= cpu_halted;
            if (wr_en && ctrl_hit) strict_q <= wbit;
        end
    end

    assign wake_strict = strict_q;
    assign wake_out    = halted_q & (|bank_wake);

    always_comb begin
        ctrl_rd    = '0;
        ctrl_rd[0] = ctrl_hit & strict_q;
    end

    AST_WAKE_NEEDS_HALT: assert property (@(posedge clk) disable iff (rst)
        wake_out |-> $past(cpu_halted)); // R8
    AST_STRICT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && ctrl_hit) |=> $stable(strict_q)); // R9

endmodule

// File: rtl/irq_line_merge.sv
module irq_line_merge
    import irq_router_pkg::*;
#(
    parameter int NB = 2
) (
    input  bank_flags_t [NB-1:0] flags,
    output logic                 irq_out,
    output logic                 fiq_out,
    output logic [NB-1:0]        wake_vec
);

    always_comb begin
        irq_out = 1'b0;
        fiq_out = 1'b0;
        for (int b = 0; b < NB; b++) begin
            irq_out     = irq_out | flags[b].irq_req;
            fiq_out     = fiq_out | flags[b].fiq_req;
            wake_vec[b] = flags[b].wake_req;
        end
    end

endmodule

// File: rtl/dual_bank_irq_router.sv
module dual_bank_irq_router
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC = 40
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SRC-1:0]  src_level,
    input  logic                cpu_halted,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [WORD_W-1:0]   reg_wdata,
    output logic [WORD_W-1:0]   reg_rdata,
    output logic                irq_out,
    output logic                fiq_out,
    output logic                wake_out
);

    localparam int NB = (NUM_SRC + WORD_W - 1) / WORD_W;

    bank_flags_t [NB-1:0]             flags;
    logic [NB-1:0][WORD_W-1:0]        bank_rd;
    logic [NB-1:0]                    bank_hit;
    logic [NB-1:0]                    wake_vec;
    logic                             wake_strict;
    logic [WORD_W-1:0]                ctrl_rd;
    logic                             ctrl_hit;
    logic [WORD_W-1:0]                rd_next;
    logic                             mapped;

    for (genvar b = 0; b < NB; b++) begin : g_bank
        localparam int LO = b * WORD_W;
        localparam int W  = (NUM_SRC - LO) < WORD_W ? (NUM_SRC - LO) : WORD_W;
        irq_bank #(
            .W    (W),
            .BASE (bank_base(b))
        ) u_bank (
            .clk         (clk),
            .rst         (rst),
            .src         (src_level[LO +: W]),
            .wr_en       (reg_wr),
            .addr        (reg_addr),
            .wdata       (reg_wdata[W-1:0]),
            .wake_strict (wake_strict),
            .flags       (flags[b]),
            .rd_val      (bank_rd[b]),
            .rd_hit      (bank_hit[b])
        );
    end

    irq_line_merge #(.NB(NB)) u_merge (
        .flags    (flags),
        .irq_out  (irq_out),
        .fiq_out  (fiq_out),
        .wake_vec (wake_vec)
    );

    irq_idle_ctrl #(.NB(NB)) u_idle (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (reg_wr),
        .addr        (reg_addr),
        .wbit        (reg_wdata[0]),
        .cpu_halted  (cpu_halted),
        .bank_wake   (wake_vec),
        .wake_strict (wake_strict),
        .wake_out    (wake_out),
        .ctrl_rd     (ctrl_rd),
        .ctrl_hit    (ctrl_hit)
    );

    always_comb begin
        rd_next = ctrl_rd;
        for (int b = 0; b < NB; b++) rd_next = rd_next | bank_rd[b];
        mapped = ctrl_hit | (|bank_hit);
    end

    always_ff @(posedge clk) begin
        if (rst) reg_rdata <= '0;
        else     reg_rdata <= rd_next;
    end

    AST_FIQ_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (rst)
        fiq_out |-> ($past(src_level) != '0)); // R4
    AST_IRQ_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> ($past(src_level) != '0)); // R5
    AST_STRICT_WAKE_ENABLED: assert property (@(posedge clk) disable iff (rst)
        (wake_strict && wake_out) |-> (irq_out || fiq_out)); // R7
    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        !mapped |=> (reg_rdata == '0)); // R9

endmodule

// File: tb/dual_bank_irq_router_test.sv
module dual_bank_irq_router_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [39:0] src;
    logic        halted;
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        irq_o, fiq_o, wake_o;

    always #2 clk = ~clk;

    dual_bank_irq_router uut (
        .clk        (clk),
        .rst        (rst),
        .src_level  (src),
        .cpu_halted (halted),
        .reg_wr     (wr),
        .reg_addr   (addr),
        .reg_wdata  (wdata),
        .reg_rdata  (rdata),
        .irq_out    (irq_o),
        .fiq_out    (fiq_o),
        .wake_out   (wake_o)
    );

    int n_chk  = 0;
    int n_fail = 0;

    logic [31:0] m_en   [2];
    logic [31:0] m_rt   [2];
    logic [31:0] m_pend [2];
    logic        m_strict;
    logic        m_halt;

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            8'h00: return m_pend[0] & m_en[0] & ~m_rt[0];
            8'h04: return m_en[0];
            8'h08: return m_rt[0];
            8'h0C: return m_pend[0] & m_en[0] & m_rt[0];
            8'h10: return m_pend[0];
            8'h14: return {31'b0, m_strict};
            8'h9C: return m_pend[1] & m_en[1] & ~m_rt[1];
            8'hA0: return m_en[1];
            8'hA4: return m_rt[1];
            8'hA8: return m_pend[1] & m_en[1] & m_rt[1];
            8'hAC: return m_pend[1];
            default: return 32'h0;
        endcase
    endfunction

    function automatic string req_of(input logic [7:0] a);
        case (a)
            8'h00, 8'h0C, 8'h9C, 8'hA8: return "R6";
            8'h04, 8'h08, 8'hA0, 8'hA4: return "R3";
            8'h10:                      return "R1";
            8'hAC:                      return "R2";
            8'h14:                      return "R7";
            default:                    return "R9";
        endcase
    endfunction

    function automatic logic exp_irq();
        return |((m_pend[0] & m_en[0] & ~m_rt[0]) | (m_pend[1] & m_en[1] & ~m_rt[1]));
    endfunction

    function automatic logic exp_fiq();
        return |((m_pend[0] & m_en[0] & m_rt[0]) | (m_pend[1] & m_en[1] & m_rt[1]));
    endfunction

    function automatic logic exp_wake();
        return m_halt & |((m_pend[0] & (m_en[0] | {32{~m_strict}})) |
                          (m_pend[1] & (m_en[1] | {32{~m_strict}})));
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Called at a falling edge: drives one cycle, advances the model, checks after the edge (R10)
    task automatic step(input logic [39:0] s, input logic h, input logic w,
                        input logic [7:0] a, input logic [31:0] d);
        logic [31:0] exp_rd;
        src = s; halted = h; wr = w; addr = a; wdata = d;
        exp_rd    = exp_read(a);
        m_pend[0] = s[31:0];
        m_pend[1] = {24'b0, s[39:32]};
        m_halt    = h;
        if (w) begin
            case (a)
                8'h04: m_en[0]   = d;
                8'h08: m_rt[0]   = d;
                8'hA0: m_en[1]   = d & 32'hFF;
                8'hA4: m_rt[1]   = d & 32'hFF;
                8'h14: m_strict  = d[0];
                default: ;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        chk(req_of(a), "read data", rdata, exp_rd);
        chk("R5", "irq_out", {31'b0, irq_o}, {31'b0, exp_irq()});
        chk("R4", "fiq_out", {31'b0, fiq_o}, {31'b0, exp_fiq()});
        chk("R8", "wake_out", {31'b0, wake_o}, {31'b0, exp_wake()});
    endtask

    function automatic logic [7:0] pick_addr(input int k);
        case (k)
            0: return 8'h00;  1: return 8'h04;  2: return 8'h08;  3: return 8'h0C;
            4: return 8'h10;  5: return 8'h14;  6: return 8'h9C;  7: return 8'hA0;
            8: return 8'hA4;  9: return 8'hA8; 10: return 8'hAC; 11: return 8'h18;
            12: return 8'h60; default: return 8'hFC;
        endcase
    endfunction

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL R10 watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; src = '0; halted = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
        for (int i = 0; i < 2; i++) begin
            m_en[i] = '0; m_rt[i] = '0; m_pend[i] = '0;
        end
        m_strict = 1'b1; m_halt = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // Reset state: enables, routes zero; strict wake reads 1 (R3, R7)
        step('0, 1'b0, 1'b0, 8'h04, '0);
        step('0, 1'b0, 1'b0, 8'hA4, '0);
        step('0, 1'b0, 1'b0, 8'h14, '0);

        // Low bank routing (R4, R5, R6)
        step('0, 1'b0, 1'b1, 8'h04, 32'hFFFF_FFFF);
        step('0, 1'b0, 1'b1, 8'h08, 32'h0000_FF00);
        step(40'h00_0000_0008, 1'b0, 1'b0, 8'h00, '0);
        step(40'h00_0000_0208, 1'b0, 1'b0, 8'h0C, '0);
        // Pending drops when input falls, no latching (R1)
        step('0, 1'b0, 1'b0, 8'h10, '0);
        step('0, 1'b0, 1'b0, 8'h10, '0);

        // High bank: only eight bits kept (R2, R3)
        step('0, 1'b0, 1'b1, 8'hA0, 32'hFFFF_FFFF);
        step('0, 1'b0, 1'b1, 8'hA4, 32'hFFFF_FF80);
        step(40'h80_0000_0000, 1'b0, 1'b0, 8'hA0, '0);
        step(40'h40_0000_0000, 1'b0, 1'b0, 8'hA8, '0);
        step(40'hC0_0000_0000, 1'b0, 1'b0, 8'hAC, '0);

        // Writes to pending views and unmapped offsets are ignored (R9)
        step('0, 1'b0, 1'b1, 8'h00, 32'hFFFF_FFFF);
        step('0, 1'b0, 1'b1, 8'h10, 32'hFFFF_FFFF);
        step('0, 1'b0, 1'b1, 8'hAC, 32'hFFFF_FFFF);
        step('0, 1'b0, 1'b1, 8'h60, 32'hFFFF_FFFF);
        step('0, 1'b0, 1'b0, 8'h60, '0);
        step('0, 1'b0, 1'b0, 8'h04, '0);

        // Disabled source wakes a halted core only with strict wake off (R7, R8)
        step('0, 1'b1, 1'b1, 8'h04, 32'h0);
        step('0, 1'b1, 1'b1, 8'hA0, 32'h0);
        step('0, 1'b1, 1'b1, 8'h14, 32'h0);
        step(40'h00_0010_0000, 1'b1, 1'b0, 8'h14, '0);
        step(40'h00_0010_0000, 1'b1, 1'b1, 8'h14, 32'h1);
        step(40'h00_0010_0000, 1'b1, 1'b0, 8'h14, '0);
        step(40'h00_0010_0000, 1'b0, 1'b1, 8'h14, 32'h0);
        step(40'h00_0010_0000, 1'b0, 1'b0, 8'h14, '0);

        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [63:0] r1, r2;
            logic [7:0]  a;
            logic [31:0] d;
            r1 = {$urandom, $urandom};
            r2 = {$urandom, $urandom};
            a  = pick_addr(int'($urandom_range(0, 13)));
            d  = $urandom & $urandom;
            if (a == 8'h14) d = {31'b0, $urandom_range(0, 1) == 1};
            step(r1[39:0] & r2[39:0] & {40{($urandom_range(0, 3) != 0)}},
                 $urandom_range(0, 1) == 1,
                 $urandom_range(0, 9) < 3,
                 a, d);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule